// File: doc/BRIEF.md
# Eight-Channel Buffered Input Capture Unit

This block timestamps events on eight external inputs. Each channel watches its own pin for a selected edge polarity. When a qualified edge arrives it copies a free-running count value into a first-stage capture register. A latch strobe can then move every loaded capture value into a second-stage holding register. Software can therefore collect two timestamps per channel before it has to service the channel.

A per-channel protection bit stops an unread register from being replaced. A capture register becomes free again when the bus reads it or when its value moves to the holding stage. A holding register becomes free only when the bus reads it. Channels 0 to 3 can each drive the capture action of their partner channel 4 to 7. An alternate flag mode raises the channel flag only once both stages hold data.

All control and readback goes through a small synchronous register bus. Reads are combinational. A read strobe marks the addressed capture or holding register as consumed.

Top module: `ic_capture_array`

## Requirements
- R1: After reset, every register address (capture 0x00-0x07, holding 0x08-0x0F, flags 0x10, protect 0x11, system 0x12, polarity 0x13/0x14) reads zero, all flags are low and both stages of every channel are empty.
- R2: The polarity field of channel i is 2 bits: bits [2i+1:2i] of 0x13 for channels 0-3, and of 0x14 (index i-4) for channels 4-7. The codes are 00 none, 01 rising, 10 falling, 11 both. A qualified pin change first sampled at clock edge k loads the count value present at edge k+2.
- R3: With the channel's protect bit clear, every capture event replaces the capture register and every transfer replaces the holding register.
- R4: With the protect bit set, a capture event is ignored while the capture register is full. The register becomes empty after a bus read of its address or after a transfer to the holding stage.
- R5: With the protect bit set, a transfer is refused while the holding register is full, and the capture register then stays full. The holding register becomes empty only after a bus read at 0x08+i.
- R6: With the buffer-enable bit (0x12 bit 1) set, a latch strobe moves every full capture register to its holding register in the same cycle. With the bit clear, the strobe has no effect. A capture in the strobe cycle lands after the transfer.
- R7: With share bit 0x12[4+j] set, channel j+4 captures on channel j's pin using channel j's polarity, and the pin of channel j+4 is ignored.
- R8: In normal flag mode, a channel flag (0x10 bit i, port bit i) rises on each capture write. Writing one to the bit clears it, and a set in the same cycle wins.
- R9: With flag mode (0x12 bit 3) and the channel's protect bit both set, the flag rises only on a capture or transfer after which both stages are full.
- R10: With mode input high, only the first write to 0x12 after reset takes effect. With mode input low, every write takes effect.
- R11: A bus read in the same cycle as a capture or transfer into the read register leaves that register marked empty.
- R12: The protect register 0x11 can be written and read at any time. Bits 0 and 2 of 0x12 are stored and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeN | input | 1 | High: system register write-once; low: unrestricted |
| addr | input | 5 | Register address |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe (consumes capture/holding data) |
| rdData | output | CNT_W | Combinational read data, zero-extended |
| pins | input | 8 | Channel inputs, asynchronous |
| latchStrobe | input | 1 | Capture-to-holding transfer request |
| count | input | CNT_W | Free-running count value |
| irqFlags | output | 8 | Per-channel flags |

## Verification
The assertions assume a flag only rises from an event strobe of its own channel or a transfer. They also assume that a protected, full register changes only through the paths the requirements allow. They rely on the bus never asserting read and write to conflicting addresses in a way that reconfigures a channel mid-event. The stimulus keeps every bus access to one cycle, holds pins for three cycles per level so that each edge clears the two-stage synchronizer, and sweeps read, strobe and clear timing relative to pulses so that same-cycle collisions occur at known offsets.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int IC_CH    = 8;
  localparam int IC_PAIRS = IC_CH / 2;
  localparam int IC_IDX_W = $clog2(IC_CH);
  localparam int IC_ADDR_W = 5;
  localparam int REG_W    = 8;

  localparam logic [IC_ADDR_W-1:0] ADDR_HOLD0  = IC_ADDR_W'(IC_CH);
  localparam logic [IC_ADDR_W-1:0] ADDR_FLAGS  = IC_ADDR_W'(2 * IC_CH);
  localparam logic [IC_ADDR_W-1:0] ADDR_NOVW   = ADDR_FLAGS + 5'd1;
  localparam logic [IC_ADDR_W-1:0] ADDR_SYS    = ADDR_FLAGS + 5'd2;
  localparam logic [IC_ADDR_W-1:0] ADDR_POL_LO = ADDR_FLAGS + 5'd3;
  localparam logic [IC_ADDR_W-1:0] ADDR_POL_HI = ADDR_FLAGS + 5'd4;

  localparam int SYS_BUFEN    = 1;
  localparam int SYS_FLAGMODE = 3;
  localparam int SYS_SHARE0   = 4;

  typedef struct packed {
    logic [IC_CH-1:0] capEv;
    logic             latchEv;
    logic [IC_CH-1:0] rdCap;
    logic [IC_CH-1:0] rdHold;
    logic [IC_CH-1:0] flagClr;
  } icStrobes_t;
endpackage

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        modeN,
  input  logic [IC_ADDR_W-1:0]        addr,
  input  logic                        wrEn,
  input  logic [REG_W-1:0]            wrData,
  input  logic                        rdEn,
  output logic [CNT_W-1:0]            rdData,
  input  logic [IC_CH-1:0]            pins,
  input  logic                        latchStrobe,
  input  logic [IC_CH-1:0][CNT_W-1:0] capVal,
  input  logic [IC_CH-1:0][CNT_W-1:0] holdVal,
  input  logic [IC_CH-1:0]            flags,
  output icStrobes_t                  strb,
  output logic [REG_W-1:0]            novwReg,
  output logic [REG_W-1:0]            sysCfg
);
  localparam int POL_W = 2 * IC_CH;

  logic [IC_CH-1:0] syncA, syncB, prevB, edgeHit, capEvN, rdCapN, rdHoldN;
  logic [POL_W-1:0] polCfg;
  logic             sysLocked, sysWrOk;
  logic [IC_ADDR_W-1:0] holdOff;

  assign sysWrOk = wrEn && (addr == ADDR_SYS) && (!modeN || !sysLocked);
  assign holdOff = addr - ADDR_HOLD0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      novwReg   <= '0;
      sysCfg    <= '0;
      polCfg    <= '0;
      sysLocked <= 1'b0;
    end else begin
      if (wrEn && addr == ADDR_NOVW)   novwReg <= wrData;
      if (wrEn && addr == ADDR_POL_LO) polCfg[REG_W-1:0] <= wrData;
      if (wrEn && addr == ADDR_POL_HI) polCfg[POL_W-1:REG_W] <= wrData;
      if (sysWrOk) begin
        sysCfg <= wrData;
        if (modeN) sysLocked <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pins;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar g = 0; g < IC_CH; g++) begin : g_chan
    logic [1:0] sel;
    assign sel = polCfg[2*g +: 2];
    assign edgeHit[g] = (sel[0] & syncB[g] & ~prevB[g]) | (sel[1] & ~syncB[g] & prevB[g]);
    assign rdCapN[g]  = rdEn && (addr == IC_ADDR_W'(g));
    assign rdHoldN[g] = rdEn && (addr == ADDR_HOLD0 + IC_ADDR_W'(g));
    if (g < IC_PAIRS) begin : g_lower
      assign capEvN[g] = edgeHit[g];
    end else begin : g_upper
      assign capEvN[g] = sysCfg[SYS_SHARE0 + g - IC_PAIRS] ? edgeHit[g - IC_PAIRS] : edgeHit[g];
    end
  end

  always_comb begin
    strb.capEv   = capEvN;
    strb.latchEv = latchStrobe & sysCfg[SYS_BUFEN];
    strb.rdCap   = rdCapN;
    strb.rdHold  = rdHoldN;
    strb.flagClr = (wrEn && addr == ADDR_FLAGS) ? wrData : '0;
  end

  always_comb begin
    rdData = '0;
    if (addr < ADDR_HOLD0)        rdData = capVal[addr[IC_IDX_W-1:0]];
    else if (addr < ADDR_FLAGS)   rdData = holdVal[holdOff[IC_IDX_W-1:0]];
    else if (addr == ADDR_FLAGS)  rdData = CNT_W'(flags);
    else if (addr == ADDR_NOVW)   rdData = CNT_W'(novwReg);
    else if (addr == ADDR_SYS)    rdData = CNT_W'(sysCfg);
    else if (addr == ADDR_POL_LO) rdData = CNT_W'(polCfg[REG_W-1:0]);
    else if (addr == ADDR_POL_HI) rdData = CNT_W'(polCfg[POL_W-1:REG_W]);
  end
endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  icStrobes_t                  strb,
  input  logic [REG_W-1:0]            novwReg,
  input  logic                        flagMode,
  input  logic [CNT_W-1:0]            count,
  output logic [IC_CH-1:0][CNT_W-1:0] capVal,
  output logic [IC_CH-1:0][CNT_W-1:0] holdVal,
  output logic [IC_CH-1:0]            capFull,
  output logic [IC_CH-1:0]            holdFull,
  output logic [IC_CH-1:0]            flags
);
  for (genvar g = 0; g < IC_CH; g++) begin : g_chan
    logic [CNT_W-1:0] capQ, holdQ;
    logic capFullQ, holdFullQ, flagQ;
    logic holdWr, capMid, capWr, capNext, holdNext, setFlag;

    always_comb begin
      // transfer first, then capture, then bus read clears status
      holdWr   = strb.latchEv & capFullQ & (~novwReg[g] | ~holdFullQ);
      capMid   = capFullQ & ~holdWr;
      capWr    = strb.capEv[g] & (~novwReg[g] | ~capMid);
      capNext  = capWr | capMid;
      holdNext = holdWr | holdFullQ;
      setFlag  = (flagMode & novwReg[g]) ? ((capWr | holdWr) & capNext & holdNext) : capWr;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        capQ      <= '0;
        holdQ     <= '0;
        capFullQ  <= 1'b0;
        holdFullQ <= 1'b0;
        flagQ     <= 1'b0;
      end else begin
        if (holdWr) holdQ <= capQ;
        if (capWr)  capQ  <= count;
        capFullQ  <= capNext  & ~strb.rdCap[g];
        holdFullQ <= holdNext & ~strb.rdHold[g];
        flagQ     <= setFlag | (flagQ & ~strb.flagClr[g]);
      end
    end

    assign capVal[g]   = capQ;
    assign holdVal[g]  = holdQ;
    assign capFull[g]  = capFullQ;
    assign holdFull[g] = holdFullQ;
    assign flags[g]    = flagQ;
  end
endmodule

// File: rtl/ic_capture_array.sv
module ic_capture_array
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeN,
  input  logic [IC_ADDR_W-1:0] addr,
  input  logic                 wrEn,
  input  logic [REG_W-1:0]     wrData,
  input  logic                 rdEn,
  output logic [CNT_W-1:0]     rdData,
  input  logic [IC_CH-1:0]     pins,
  input  logic                 latchStrobe,
  input  logic [CNT_W-1:0]     count,
  output logic [IC_CH-1:0]     irqFlags
);
  icStrobes_t                  strb;
  logic [REG_W-1:0]            novwReg, sysCfg;
  logic [IC_CH-1:0][CNT_W-1:0] capVal, holdVal;
  logic [IC_CH-1:0]            capFull, holdFull;

  ic_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeN(modeN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .pins(pins),
    .latchStrobe(latchStrobe), .capVal(capVal), .holdVal(holdVal),
    .flags(irqFlags), .strb(strb), .novwReg(novwReg), .sysCfg(sysCfg)
  );

  ic_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .novwReg(novwReg),
    .flagMode(sysCfg[SYS_FLAGMODE]), .count(count), .capVal(capVal),
    .holdVal(holdVal), .capFull(capFull), .holdFull(holdFull), .flags(irqFlags)
  );
endmodule

// File: rtl/ic_capture_array_chk.sv
module ic_capture_array_chk
  import ic_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        modeN,
  input logic [IC_ADDR_W-1:0]        addr,
  input logic                        wrEn,
  input logic [REG_W-1:0]            wrData,
  input icStrobes_t                  strb,
  input logic [REG_W-1:0]            novwReg,
  input logic [REG_W-1:0]            sysCfg,
  input logic [IC_CH-1:0][CNT_W-1:0] capVal,
  input logic [IC_CH-1:0][CNT_W-1:0] holdVal,
  input logic [IC_CH-1:0]            capFull,
  input logic [IC_CH-1:0]            holdFull,
  input logic [IC_CH-1:0]            irqFlags
);
  logic sysSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysSeen <= 1'b0;
    else if (wrEn && addr == ADDR_SYS && modeN) sysSeen <= 1'b1;
  end

  AST_SYS_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    sysSeen && modeN && wrEn && addr == ADDR_SYS |=> $stable(sysCfg)); // R10

  for (genvar g = 0; g < IC_CH; g++) begin : g_chk
    AST_CAP_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      novwReg[g] && capFull[g] && !strb.latchEv |=> $stable(capVal[g])); // R4
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      novwReg[g] && holdFull[g] |=> $stable(holdVal[g])); // R5
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqFlags[g]) |-> $past(strb.capEv[g] || strb.latchEv)); // R8
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rstN)
      wrEn && addr == ADDR_FLAGS && wrData[g] && !strb.capEv[g] && !strb.latchEv |=> !irqFlags[g]); // R8
    AST_PAIR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      sysCfg[SYS_FLAGMODE] && novwReg[g] && !holdFull[g] && !strb.latchEv |=> !$rose(irqFlags[g])); // R9
  end
endmodule

bind ic_capture_array ic_capture_array_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .modeN(modeN), .addr(addr), .wrEn(wrEn),
  .wrData(wrData), .strb(strb), .novwReg(novwReg), .sysCfg(sysCfg),
  .capVal(capVal), .holdVal(holdVal), .capFull(capFull), .holdFull(holdFull),
  .irqFlags(irqFlags)
);

// File: tb/ic_capture_array_tb_top.sv
`timescale 1ns/1ps
module ic_capture_array_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0, modeN = 1'b1, wrEn = 1'b0, rdEn = 1'b0, latch = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wrData = '0, pins = '0;
  logic [15:0] count = '0;
  logic [15:0] rdData;
  logic [7:0] irqFlags;

  int checks = 0, failures = 0;
  bit done = 0;
  string curTag = "R1";

  always #2.5 clk = ~clk;
  always @(negedge clk) count <= count + 16'd1;

  ic_capture_array #(.CNT_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .modeN(modeN), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .pins(pins),
    .latchStrobe(latch), .count(count), .irqFlags(irqFlags)
  );

  // reference model state
  logic [15:0] mCap [8];
  logic [15:0] mHold [8];
  logic [7:0]  mCapF, mHoldF, mFlags, mNovw, mSys, mS1, mS2, mPrev, ev, evS;
  logic [15:0] mPol;
  bit mLock;

  function automatic logic [15:0] mRead(input logic [4:0] a);
    if (a < 8)   return mCap[a[2:0]];
    if (a < 16)  return mHold[a[2:0]];
    case (a)
      16: return {8'h0, mFlags};
      17: return {8'h0, mNovw};
      18: return {8'h0, mSys};
      19: return {8'h0, mPol[7:0]};
      20: return {8'h0, mPol[15:8]};
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) begin mCap[i] = '0; mHold[i] = '0; end
      mCapF = '0; mHoldF = '0; mFlags = '0; mNovw = '0; mSys = '0;
      mS1 = '0; mS2 = '0; mPrev = '0; mPol = '0; mLock = 0;
    end else begin
      for (int i = 0; i < 8; i++)
        ev[i] = (mPol[2*i] && mS2[i] && !mPrev[i]) || (mPol[2*i+1] && !mS2[i] && mPrev[i]);
      for (int i = 0; i < 8; i++)
        evS[i] = (i >= 4 && mSys[i]) ? ev[i-4] : ev[i];
      for (int i = 0; i < 8; i++) begin
        bit hw, cw, st;
        hw = latch && mSys[1] && mCapF[i] && (!mNovw[i] || !mHoldF[i]);
        if (hw) begin mHold[i] = mCap[i]; mHoldF[i] = 1; mCapF[i] = 0; end
        cw = evS[i] && (!mNovw[i] || !mCapF[i]);
        if (cw) begin mCap[i] = count; mCapF[i] = 1; end
        if (mSys[3] && mNovw[i]) st = (cw || hw) && mCapF[i] && mHoldF[i];
        else st = cw;
        if (wrEn && addr == 16 && wrData[i]) mFlags[i] = 0;
        if (st) mFlags[i] = 1;
        if (rdEn && addr == 5'(i)) mCapF[i] = 0;
        if (rdEn && addr == 5'(8 + i)) mHoldF[i] = 0;
      end
      if (wrEn) begin
        if (addr == 17) mNovw = wrData;
        if (addr == 19) mPol[7:0] = wrData;
        if (addr == 20) mPol[15:8] = wrData;
        if (addr == 18 && (!modeN || !mLock)) begin mSys = wrData; if (modeN) mLock = 1; end
      end
      mPrev = mS2; mS2 = mS1; mS1 = pins;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk(irqFlags == mFlags, curTag, "flags", irqFlags, mFlags);
      if (rdEn) chk(rdData == mRead(addr), curTag, $sformatf("read@%0h", addr), rdData, mRead(addr));
    end
  end

  task automatic doReset(input logic m);
    @(negedge clk); rstN = 0; modeN = m;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic busRead(input logic [4:0] a, input string tag);
    @(negedge clk); curTag = tag; rdEn = 1; addr = a;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic pulse(input int ch);
    @(negedge clk); pins[ch] = 1;
    repeat (3) @(negedge clk); pins[ch] = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobeLatch();
    @(negedge clk); latch = 1;
    @(negedge clk); latch = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    doReset(1'b1);
    curTag = "R1";
    for (int a = 0; a < 21; a++) busRead(5'(a), "R1");
    // R10 write-once in normal mode
    curTag = "R10";
    busWrite(18, 8'h02); busRead(18, "R10");
    busWrite(18, 8'hFF); busRead(18, "R10");
    // R12 protect register and stored system bits
    busWrite(17, 8'hA5); busRead(17, "R12");
    busWrite(17, 8'h00); busRead(17, "R12");
    doReset(1'b0);
    busWrite(18, 8'h05); busRead(18, "R12");
    busWrite(18, 8'hF0); busRead(18, "R10");
    busWrite(18, 8'h02); busRead(18, "R10");

    // R2 polarity
    curTag = "R2";
    busWrite(19, 8'h79); busWrite(20, 8'h55);
    busRead(19, "R2"); busRead(20, "R2");
    pulse(0); busRead(0, "R2");
    @(negedge clk); pins[1] = 1; repeat (4) @(negedge clk); busRead(1, "R2");
    pins[1] = 0; repeat (4) @(negedge clk); busRead(1, "R2");
    @(negedge clk); pins[2] = 1; repeat (4) @(negedge clk); busRead(2, "R2");
    pins[2] = 0; repeat (4) @(negedge clk); busRead(2, "R2");
    busWrite(20, 8'h54); pulse(4); busRead(4, "R2");

    // R3 overwrite when unprotected
    curTag = "R3";
    pulse(0); pulse(0); busRead(0, "R3");
    pulse(0); strobeLatch(); pulse(0); strobeLatch(); busRead(8, "R3");

    // R4 protected capture
    curTag = "R4";
    busWrite(17, 8'hFF); busRead(0, "R4"); busRead(8, "R4");
    pulse(0); pulse(0); busRead(0, "R4"); busRead(0, "R4");
    pulse(0); busRead(0, "R4");

    // R5 / R6 holding stage
    curTag = "R6";
    pulse(0); strobeLatch(); busRead(8, "R6");
    pulse(0); strobeLatch(); busRead(0, "R4");
    pulse(0); strobeLatch();
    curTag = "R5"; busRead(8, "R5");
    pulse(0); strobeLatch(); busRead(8, "R5"); busRead(0, "R5");
    busRead(8, "R5"); strobeLatch(); busRead(8, "R6");
    busWrite(17, 8'h00);
    for (int k = 0; k < 6; k++) begin
      fork
        pulse(3);
        begin repeat (k) @(negedge clk); strobeLatch(); end
      join
      busRead(3, "R6"); busRead(11, "R6");
    end
    busWrite(18, 8'h00); pulse(3); strobeLatch(); busRead(11, "R6");

    // R7 sharing
    curTag = "R7";
    busWrite(18, 8'h10); busWrite(20, 8'h55);
    pulse(0); busRead(4, "R7");
    pulse(4); busRead(4, "R7");
    busWrite(18, 8'h00); pulse(4); busRead(4, "R7");

    // R8 flags in normal mode
    curTag = "R8";
    busWrite(16, 8'hFF); pulse(3); busRead(16, "R8");
    busWrite(16, 8'h08); busRead(16, "R8");
    for (int k = 0; k < 6; k++) begin
      fork
        pulse(3);
        begin repeat (k) @(negedge clk); busWrite(16, 8'h08); end
      join
      busRead(16, "R8");
    end

    // R9 flag only when both stages full
    curTag = "R9";
    busWrite(18, 8'h0A); busWrite(17, 8'hFF); busWrite(16, 8'hFF);
    busRead(0, "R9"); busRead(8, "R9"); busWrite(16, 8'hFF);
    pulse(0); busRead(16, "R9");
    strobeLatch(); busRead(16, "R9");
    pulse(0); busRead(16, "R9");
    busWrite(16, 8'hFF); busRead(8, "R9"); strobeLatch(); busRead(16, "R9");

    // R11 read colliding with capture
    curTag = "R11";
    busWrite(18, 8'h00); busWrite(16, 8'hFF);
    for (int k = 0; k < 6; k++) begin
      busRead(5, "R11");
      fork
        pulse(5);
        begin repeat (k) @(negedge clk); busRead(5, "R11"); end
      join
      pulse(5); busRead(5, "R11");
    end
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule